// File: doc/BRIEF.md
# Receive Station Address Filter

This block decides, frame by frame, whether an incoming frame is kept. Each frame is presented as its 48-bit destination address together with a one-cycle valid strobe. The block sorts the address into broadcast, multicast or unicast, compares it with the programmed station address, and one clock later gives an accept/reject verdict together with the class tag.

Software configures the filter through an index register and a data register. The index picks one of three 16-bit station address words or the filter mode word. Writes to the data register land in the selected word. The data read port always shows the word that the current index selects. The mode word holds a global enable, three per-class accept-all flags and an exact-match flag. A frame is accepted only when the enable is set and at least one flag that applies to the frame is set.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the station address and the mode word are zero, the index is 0, the read port returns 0 and no decision is reported.
- R2: Station words sit at indices 0, 2 and 4 and read back as written in bits 15:0, with bits 31:16 read as zero. In each word, bits 7:0 hold the earlier address octet and bits 15:8 the octet that follows it, so index 0 holds octets 0 and 1.
- R3: The mode word sits at index 16. Only bits 31:27 are stored: 31 enable, 30 accept broadcast, 29 accept multicast, 28 accept unicast, 27 accept exact station match. All other bits read as zero.
- R4: At any other index, a data write changes nothing and a read returns zero.
- R5: The decision appears on `dec_valid` exactly one clock after `frm_valid` is sampled high, and it lasts one cycle per frame. Back-to-back frames give back-to-back decisions, and `dec_accept` is low whenever `dec_valid` is low.
- R6: `dec_class` is 2 for an all-ones destination, 1 for any other destination whose group bit (the least significant bit of octet 0, `frm_dst[40]`) is set, and 0 otherwise. Octet 0 is `frm_dst[47:40]`.
- R7: While the enable bit is clear, every frame is rejected, whatever the other mode bits hold.
- R8: With the enable set, the broadcast flag accepts every broadcast frame.
- R9: With the enable set, the multicast flag accepts every class-1 frame. It does not accept broadcast frames.
- R10: With the enable set, the unicast flag accepts every class-0 frame.
- R11: With the enable set, the exact flag accepts a frame only when all six octets equal the station address in octet order.
- R12: The mode enable + broadcast + exact accepts broadcast frames and frames sent to the station. It rejects other multicast frames and other unicast frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx_we | input | 1 | Load the index register |
| cfg_idx | input | 8 | New index value |
| cfg_data_we | input | 1 | Write the word selected by the current index |
| cfg_wdata | input | 32 | Data register write value |
| cfg_rdata | output | 32 | Word selected by the current index |
| frm_valid | input | 1 | Destination address valid strobe |
| frm_dst | input | 48 | Destination address, octet 0 in bits 47:40 |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_class | output | 2 | Address class: 0 unicast, 1 multicast, 2 broadcast |

## Verification
Some properties are checked by the assertions on every cycle. These are the one-cycle decision latency, the absence of an accept without a decision strobe, and the class tag chosen from the all-ones and group-bit tests. They also cover rejection whenever the enable is clear, and read-back of a mode or station word right after it is written. The bench scenarios must show the rest. That means the accept verdict under each flag combination, the octet order of the exact compare including a near miss and a byte-swapped station, the exclusion of broadcast from accept-all-multicast, and writes to unmapped indices having no effect.

// File: rtl/rsaf_pkg.sv
package rsaf_pkg;

   typedef enum logic [1:0] {
      CLS_UCAST = 2'd0,
      CLS_MCAST = 2'd1,
      CLS_BCAST = 2'd2
   } dst_class_e;

   // Bit positions of the stored mode flags inside the 32-bit mode word
   localparam int MODE_LSB = 27;
   localparam int MODE_BITS = 5;

   typedef struct packed {
      logic en;      // bit 31
      logic bcast;   // bit 30
      logic mcast;   // bit 29
      logic ucast;   // bit 28
      logic exact;   // bit 27
   } mode_t;

endpackage

// File: rtl/rsaf_regs.sv
module rsaf_regs
   import rsaf_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int DATA_W = 32,
   parameter int WORD_W = 16,
   parameter int NUM_WORDS = 3,
   parameter int WORD_STRIDE = 2,
   parameter int MODE_IDX = 16,
   localparam int ADDR_W = NUM_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_we,
   input  logic [IDX_W-1:0]  idx_in,
   input  logic              data_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [ADDR_W-1:0] station,
   output mode_t             mode
);

   localparam int BPW = WORD_W / 8;
   localparam logic [IDX_W-1:0] MODE_SEL = IDX_W'(MODE_IDX);

   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("rsaf_regs: WORD_W must be a whole number of octets");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("rsaf_regs: mode flags need a 32-bit data register");
   end
   if (MODE_IDX < NUM_WORDS * WORD_STRIDE && MODE_IDX % WORD_STRIDE == 0) begin : g_bad_mode
      $error("rsaf_regs: MODE_IDX collides with a station word");
   end
   if ((NUM_WORDS - 1) * WORD_STRIDE >= (1 << IDX_W) || MODE_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("rsaf_regs: index width too small");
   end

   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] word_q [NUM_WORDS];
   mode_t             mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= '0;
      else if (idx_we) idx_q <= idx_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= '0;
      else if (data_we && idx_q == MODE_SEL)
         mode_q <= mode_t'(wdata[MODE_LSB +: MODE_BITS]);
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam logic [IDX_W-1:0] SEL = IDX_W'(w * WORD_STRIDE);

      always_ff @(posedge clk) begin
         if (!rst_n) word_q[w] <= '0;
         else if (data_we && idx_q == SEL) word_q[w] <= wdata[WORD_W-1:0];
      end

      // low byte of each word is the earlier octet on the wire
      for (genvar b = 0; b < BPW; b++) begin : g_oct
         assign station[ADDR_W-1 - (w*BPW + b)*8 -: 8] = word_q[w][b*8 +: 8];
      end
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (idx_q == IDX_W'(w * WORD_STRIDE)) rdata[WORD_W-1:0] = word_q[w];
      end
      if (idx_q == MODE_SEL) rdata[MODE_LSB +: MODE_BITS] = mode_q;
   end

   wire unused_wbits = ^wdata[MODE_LSB-1:WORD_W];

   assign cur_idx = idx_q;
   assign mode    = mode_q;

endmodule

// File: rtl/rsaf_classify.sv
module rsaf_classify
   import rsaf_pkg::*;
#(
   parameter int ADDR_W = 48,
   localparam int NUM_OCT = ADDR_W / 8
) (
   input  logic [ADDR_W-1:0] dst,
   input  logic [ADDR_W-1:0] station,
   output dst_class_e        cls,
   output logic              exact_hit
);

   if (ADDR_W % 8 != 0) begin : g_bad_addr
      $error("rsaf_classify: address must be whole octets");
   end

   logic [NUM_OCT-1:0] oct_eq;
   logic [NUM_OCT-1:0] oct_ones;

   for (genvar k = 0; k < NUM_OCT; k++) begin : g_oct
      assign oct_eq[k]   = (dst[k*8 +: 8] == station[k*8 +: 8]);
      assign oct_ones[k] = &dst[k*8 +: 8];
   end

   logic all_ones, group_bit;
   assign all_ones  = &oct_ones;
   assign group_bit = dst[ADDR_W-8];
   assign exact_hit = &oct_eq;

   always_comb begin
      if (all_ones)       cls = CLS_BCAST;
      else if (group_bit) cls = CLS_MCAST;
      else                cls = CLS_UCAST;
   end

endmodule

// File: rtl/rsaf_decide.sv
module rsaf_decide
   import rsaf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frm_valid,
   input  dst_class_e cls,
   input  logic       exact_hit,
   input  mode_t      mode,
   output logic       dec_valid,
   output logic       dec_accept,
   output dst_class_e dec_class
);

   logic class_ok, hit;

   always_comb begin
      unique case (cls)
         CLS_BCAST: class_ok = mode.bcast;
         CLS_MCAST: class_ok = mode.mcast;
         default:   class_ok = mode.ucast;
      endcase
   end

   assign hit = mode.en && (class_ok || (mode.exact && exact_hit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_class  <= CLS_UCAST;
      end else begin
         dec_valid  <= frm_valid;
         dec_accept <= frm_valid && hit;
         if (frm_valid) dec_class <= cls;
      end
   end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rsaf_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int DATA_W = 32,
   parameter int WORD_W = 16,
   parameter int NUM_WORDS = 3,
   parameter int WORD_STRIDE = 2,
   parameter int MODE_IDX = 16,
   localparam int ADDR_W = NUM_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_idx_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_data_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              frm_valid,
   input  logic [ADDR_W-1:0] frm_dst,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [1:0]        dec_class
);

   logic [ADDR_W-1:0] station;
   logic [IDX_W-1:0]  cur_idx;
   mode_t             mode;
   dst_class_e        cls, cls_q;
   logic              exact_hit;
   logic              mode_en;

   rsaf_regs #(
      .IDX_W(IDX_W), .DATA_W(DATA_W), .WORD_W(WORD_W),
      .NUM_WORDS(NUM_WORDS), .WORD_STRIDE(WORD_STRIDE), .MODE_IDX(MODE_IDX)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .idx_we(cfg_idx_we), .idx_in(cfg_idx),
      .data_we(cfg_data_we), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .cur_idx(cur_idx),
      .station(station), .mode(mode)
   );

   rsaf_classify #(.ADDR_W(ADDR_W)) u_cls (
      .dst(frm_dst), .station(station), .cls(cls), .exact_hit(exact_hit)
   );

   rsaf_decide u_dec (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
      .cls(cls), .exact_hit(exact_hit), .mode(mode),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_class(cls_q)
   );

   assign dec_class = cls_q;
   assign mode_en   = mode.en;

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
   parameter int IDX_W = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 48,
   parameter int MODE_IDX = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_idx_we,
   input logic              cfg_data_we,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic [IDX_W-1:0]  cur_idx,
   input logic              mode_en,
   input logic              frm_valid,
   input logic [ADDR_W-1:0] frm_dst,
   input logic              dec_valid,
   input logic              dec_accept,
   input logic [1:0]        dec_class
);

   AST_DEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> dec_valid);                                          // R5
   AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> !dec_valid);                                        // R5
   AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_accept);                                       // R5
   AST_BCAST_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && &frm_dst) |=> dec_class == 2'd2);                    // R6
   AST_MCAST_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_dst[ADDR_W-8] && !(&frm_dst)) |=> dec_class == 2'd1); // R6
   AST_UCAST_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !frm_dst[ADDR_W-8]) |=> dec_class == 2'd0);          // R6
   AST_DISABLED_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !mode_en) |=> !dec_accept);                          // R7
   AST_MODE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_data_we && !cfg_idx_we && cur_idx == IDX_W'(MODE_IDX))
      |=> cfg_rdata == {$past(cfg_wdata[31:27]), 27'b0});                // R3
   AST_WORD0_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_data_we && !cfg_idx_we && cur_idx == '0)
      |=> cfg_rdata == {16'b0, $past(cfg_wdata[15:0])});                 // R2

endmodule

bind rx_addr_filter rx_addr_filter_chk #(
   .IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_IDX(MODE_IDX)
) chk (
   .clk(clk), .rst_n(rst_n), .cfg_idx_we(cfg_idx_we), .cfg_data_we(cfg_data_we),
   .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cur_idx(cur_idx),
   .mode_en(mode_en), .frm_valid(frm_valid), .frm_dst(frm_dst),
   .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_class(dec_class)
);

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_idx_we = 1'b0;
   logic [7:0]  cfg_idx = '0;
   logic        cfg_data_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        frm_valid = 1'b0;
   logic [47:0] frm_dst = '0;
   logic        dec_valid, dec_accept;
   logic [1:0]  dec_class;

   rx_addr_filter uut (.*);

   always #2.5 clk = ~clk;

   int checks = 0;
   int fails = 0;
   int cycle = 0;
   bit done = 1'b0;

   always @(posedge clk) cycle <= cycle + 1;

   typedef struct {
      int          due;
      logic        acc;
      logic [1:0]  cls;
      string       tag;
   } exp_t;
   exp_t sb[$];

   // bench copy of programmed state
   logic [15:0] w0 = 0, w1 = 0, w2 = 0;
   logic [31:0] m = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_idx(input logic [7:0] i);
      @(negedge clk); cfg_idx_we = 1'b1; cfg_idx = i;
      @(posedge clk); #1 cfg_idx_we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] i, input logic [31:0] d);
      set_idx(i);
      @(negedge clk); cfg_data_we = 1'b1; cfg_wdata = d;
      @(posedge clk); #1 cfg_data_we = 1'b0;
      if (i == 8'd0) w0 = d[15:0];
      if (i == 8'd2) w1 = d[15:0];
      if (i == 8'd4) w2 = d[15:0];
      if (i == 8'd16) m = d & 32'hF800_0000;
   endtask

   task automatic rd(input string tag, input logic [7:0] i, input logic [31:0] exp);
      set_idx(i);
      @(negedge clk);
      chk(tag, cfg_rdata, exp);
   endtask

   function automatic logic [2:0] model(input logic [47:0] d);
      logic [47:0] st;
      logic [1:0]  c;
      logic        ok;
      st = {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]};
      c  = (d == '1) ? 2'd2 : (d[40] ? 2'd1 : 2'd0);
      ok = (c == 2'd2 && m[30]) || (c == 2'd1 && m[29]) ||
           (c == 2'd0 && m[28]) || (m[27] && d == st);
      return {m[31] && ok, c};
   endfunction

   task automatic send(input string tag, input logic [47:0] d);
      exp_t e;
      logic [2:0] r;
      @(negedge clk);
      frm_valid = 1'b1; frm_dst = d;
      r = model(d);
      e.due = cycle + 1; e.acc = r[2]; e.cls = r[1:0]; e.tag = tag;
      sb.push_back(e);
      @(posedge clk); #1 frm_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
      chk("R5 idle no decision", {31'b0, dec_valid}, 32'd0);
      chk("R5 queue empty", sb.size(), 0);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         if (sb.size() == 0) begin
            checks++; fails++;
            $display("FAIL R5 unexpected decision: actual 1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " R5 timing"}, cycle, e.due);
            chk({e.tag, " accept"}, {31'b0, dec_accept}, {31'b0, e.acc});
            chk({e.tag, " R6 class"}, {30'b0, dec_class}, {30'b0, e.cls});
         end
      end
   end

   localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
   localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;
   localparam logic [47:0] OTHER = 48'h00_AA_BB_CC_DD_EE;

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdata idx0", cfg_rdata, 32'd0);
      chk("R1 no decision", {31'b0, dec_valid}, 32'd0);
      rd("R1 mode zero", 8'd16, 32'd0);

      wr(8'd0, 32'hDEAD_1102);
      wr(8'd2, 32'h0000_3322);
      wr(8'd4, 32'h0000_5544);
      rd("R2 word0", 8'd0, 32'h0000_1102);
      rd("R2 word1", 8'd2, 32'h0000_3322);
      rd("R2 word2", 8'd4, 32'h0000_5544);

      wr(8'd1, 32'hFFFF_ABCD);
      wr(8'd17, 32'hFFFF_FFFF);
      rd("R4 idx1 reads zero", 8'd1, 32'd0);
      rd("R4 idx17 reads zero", 8'd17, 32'd0);
      rd("R4 word0 kept", 8'd0, 32'h0000_1102);
      rd("R4 mode kept", 8'd16, 32'd0);

      wr(8'd16, 32'hFFFF_FFFF);
      rd("R3 mode bits", 8'd16, 32'hF800_0000);

      wr(8'd16, 32'h7800_0000);
      send("R7 bcast", BCAST);
      send("R7 station", STA);
      send("R7 mcast", MCAST);
      send("R7 other", OTHER);
      drain();

      wr(8'd16, 32'hC800_0000);
      send("R12 bcast", BCAST);
      send("R12 station", STA);
      send("R12 mcast", MCAST);
      send("R12 other", OTHER);
      drain();

      wr(8'd16, 32'hA000_0000);
      send("R9 mcast", MCAST);
      send("R9 bcast excluded", BCAST);
      send("R9 other", OTHER);
      drain();

      wr(8'd16, 32'h9000_0000);
      send("R10 other", OTHER);
      send("R10 station", STA);
      send("R10 mcast", MCAST);
      drain();

      wr(8'd16, 32'h8800_0000);
      send("R11 station", STA);
      send("R11 last octet off", 48'h02_11_22_33_44_54);
      send("R11 swapped octets", 48'h11_02_33_22_55_44);
      drain();

      wr(8'd16, 32'hC000_0000);
      send("R8 bcast", BCAST);
      send("R8 station", STA);
      drain();

      chk("R8 accept seen", {31'b0, dec_accept}, 32'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule